// File: doc/BRIEF.md
# Dual-Port Atomic Lock Register Bank

This block holds a bank of single-bit semaphore registers that two processor cores share for mutual-exclusion locks and barrier counting. Each core owns a request port. An ordinary uncached read issued on that port carries an address. The low address bits pick one register, and the two bits above them pick what happens to it. The bank returns the value the register held before the access. In the same step it writes the new value, so no other access can slip in between the test and the update.

Both ports are accepted in every cycle and there is no stall signal. When both ports touch the same register in one cycle, the bank treats the pair as if port 0 ran first and port 1 ran second. Software can build a spin lock by looping on test-and-set until it reads 0. It releases the lock with a clear. A barrier is a set of flags that each core raises with test-and-set and polls with plain reads.

Top module: `lockbank_dual`

## Requirements
- R1: After reset every register reads 0, and neither response-valid output is high until a request has been made.
- R2: A request on either port produces a response-valid pulse in the next cycle. The response carries the register's value as it stood before that request.
- R3: Operation code 2'b01 (test-and-set, in address bits [IDX_W+1:IDX_W]) returns the prior value and leaves the register at 1.
- R4: Operation code 2'b10 (clear) returns the prior value and leaves the register at 0.
- R5: Operation codes 2'b00 and 2'b11 (plain read) return the value and change no register.
- R6: Both ports are served in every cycle with no backpressure. Accesses to different registers in the same cycle take effect together.
- R7: When both ports address the same register in one cycle, port 1 observes the value after port 0's operation. In particular, two test-and-sets give port 0 the old value and give port 1 the value 1.
- R8: When a clear and a test-and-set hit the same register in one cycle, the register ends with the result of port 1's operation.
- R9: Address bits [IDX_W-1:0] select the register. Operations on one register never alter any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Port 0 request strobe |
| a_addr | input | IDX_W+2 | Port 0 address: operation code in the top two bits, register index below |
| a_rvalid | output | 1 | Port 0 response valid, one cycle after the request |
| a_rdata | output | 1 | Port 0 value before its operation |
| b_req | input | 1 | Port 1 request strobe |
| b_addr | input | IDX_W+2 | Port 1 address, same layout as port 0 |
| b_rvalid | output | 1 | Port 1 response valid, one cycle after the request |
| b_rdata | output | 1 | Port 1 value before its operation, seen after port 0's operation |

## Verification
A corrupted register bit stays hidden until some port reads that register. The error then shows up on the returned data one cycle after that read. Because of this, the random phase confines its indices to a small window so that every bit is re-read within a few cycles. A wrong same-cycle ordering shows up directly in the cycle after the collision: port 1's data disagrees with the serial model. Any later read of the contested register exposes the wrong final value. Full sweeps of the bank after reset and after targeted writes catch writes that land on the wrong index.

// File: rtl/lkb_pkg.sv
package lkb_pkg;

  typedef enum logic [1:0] {
    OP_PEEK  = 2'b00,
    OP_GRAB  = 2'b01,
    OP_DROP  = 2'b10,
    OP_PEEK2 = 2'b11
  } lkb_op_e;

  // true when the operation may change the register
  function automatic logic op_writes(lkb_op_e op);
    return (op == OP_GRAB) || (op == OP_DROP);
  endfunction

  // value the register holds after the operation
  function automatic logic op_next(lkb_op_e op, logic old_v);
    case (op)
      OP_GRAB: return 1'b1;
      OP_DROP: return 1'b0;
      default: return old_v;
    endcase
  endfunction

endpackage

// File: rtl/lkb_decode.sv
module lkb_decode
  import lkb_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic               req_i,
  input  logic [IDX_W+1:0]   addr_i,
  output logic [IDX_W-1:0]   idx_o,
  output lkb_op_e            op_o,
  output logic               wr_o
);
  assign idx_o = addr_i[IDX_W-1:0];
  assign op_o  = lkb_op_e'(addr_i[IDX_W+1:IDX_W]);
  assign wr_o  = req_i && op_writes(op_o);
endmodule

// File: rtl/lkb_resolve.sv
module lkb_resolve
  import lkb_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned NUM  = 1 << IDX_W
) (
  input  logic [NUM-1:0]   state_i,
  input  logic             req0_i,
  input  logic [IDX_W-1:0] idx0_i,
  input  lkb_op_e          op0_i,
  input  logic [IDX_W-1:0] idx1_i,
  input  lkb_op_e          op1_i,
  output logic             old0_o,
  output logic             new0_o,
  output logic             old1_o,
  output logic             new1_o,
  output logic             same_o
);
  // port 0 is ordered first; port 1 sees its outcome on a shared index
  assign same_o = req0_i && (idx0_i == idx1_i);
  assign old0_o = state_i[idx0_i];
  assign new0_o = op_next(op0_i, old0_o);
  assign old1_o = same_o ? new0_o : state_i[idx1_i];
  assign new1_o = op_next(op1_i, old1_o);
endmodule

// File: rtl/lkb_array.sv
module lkb_array #(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned NUM  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we0_i,
  input  logic [IDX_W-1:0] idx0_i,
  input  logic             d0_i,
  input  logic             we1_i,
  input  logic [IDX_W-1:0] idx1_i,
  input  logic             d1_i,
  output logic [NUM-1:0]   state_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_bit
    logic hit0, hit1, bit_q;
    assign hit0 = we0_i && (idx0_i == IDX_W'(i));
    assign hit1 = we1_i && (idx1_i == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)    bit_q <= 1'b0;
      else if (hit1) bit_q <= d1_i;   // later port wins
      else if (hit0) bit_q <= d0_i;
    end
    assign state_o[i] = bit_q;
  end
endmodule

// File: rtl/lockbank_dual.sv
module lockbank_dual
  import lkb_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned NUM  = 1 << IDX_W,
  localparam int unsigned AW   = IDX_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic [AW-1:0] a_addr,
  output logic          a_rvalid,
  output logic          a_rdata,
  input  logic          b_req,
  input  logic [AW-1:0] b_addr,
  output logic          b_rvalid,
  output logic          b_rdata
);
  logic [IDX_W-1:0] idx0, idx1;
  lkb_op_e          op0, op1;
  logic             wr0, wr1;
  logic             old0, new0, old1, new1, same_bit;
  logic [NUM-1:0]   state_q;

  lkb_decode #(.IDX_W(IDX_W)) u_dec0 (
    .req_i(a_req), .addr_i(a_addr), .idx_o(idx0), .op_o(op0), .wr_o(wr0));
  lkb_decode #(.IDX_W(IDX_W)) u_dec1 (
    .req_i(b_req), .addr_i(b_addr), .idx_o(idx1), .op_o(op1), .wr_o(wr1));

  lkb_resolve #(.IDX_W(IDX_W)) u_res (
    .state_i(state_q), .req0_i(a_req), .idx0_i(idx0), .op0_i(op0),
    .idx1_i(idx1), .op1_i(op1),
    .old0_o(old0), .new0_o(new0), .old1_o(old1), .new1_o(new1),
    .same_o(same_bit));

  lkb_array #(.IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we0_i(wr0), .idx0_i(idx0), .d0_i(new0),
    .we1_i(wr1), .idx1_i(idx1), .d1_i(new1),
    .state_o(state_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0; a_rdata <= 1'b0;
      b_rvalid <= 1'b0; b_rdata <= 1'b0;
    end else begin
      a_rvalid <= a_req; a_rdata <= a_req ? old0 : 1'b0;
      b_rvalid <= b_req; b_rdata <= b_req ? old1 : 1'b0;
    end
  end

  // named events for the checks below
  logic b_clears_same;
  logic both_grab_same;
  logic no_writer;
  assign b_clears_same  = b_req && same_bit && (op1 == OP_DROP);
  assign both_grab_same = a_req && b_req && same_bit &&
                          (op0 == OP_GRAB) && (op1 == OP_GRAB);
  assign no_writer      = !wr0 && !wr1;

  p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && b_req) |=> (a_rvalid && b_rvalid));
  p_grab_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && op0 == OP_GRAB && !b_clears_same) |=> state_q[$past(idx0)]);
  p_drop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && op1 == OP_DROP) |=> !state_q[$past(idx1)]);
  p_peek_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    no_writer |=> $stable(state_q));
  p_grab_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    both_grab_same |=> (b_rdata && state_q[$past(idx0)]));
endmodule

// File: tb/sim_lockbank_dual.sv
module sim_lockbank_dual;
  localparam int IDX_W = 8;
  localparam int NUM   = 1 << IDX_W;
  localparam int AW    = IDX_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_req = 1'b0, b_req = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_rvalid, a_rdata, b_rvalid, b_rdata;

  int checks = 0, errors = 0, cycles = 0;
  bit model [NUM];

  always #2 clk = ~clk;  // 250 MHz

  lockbank_dual #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_addr(a_addr), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_req(b_req), .b_addr(b_addr), .b_rvalid(b_rvalid), .b_rdata(b_rdata));

  function automatic bit after_op(logic [1:0] op, bit v);
    if (op == 2'b01) return 1'b1;
    if (op == 2'b10) return 1'b0;
    return v;
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog");
      summary();
    end
  end

  // one cycle of access on both ports, checked against a serial model
  task automatic step(bit va, logic [1:0] oa, int ia, bit vb, logic [1:0] ob, int ib,
                      string tag);
    bit ea, eb;
    a_req = va; a_addr = {oa, IDX_W'(ia)};
    b_req = vb; b_addr = {ob, IDX_W'(ib)};
    ea = model[ia];
    if (va) model[ia] = after_op(oa, model[ia]);
    eb = model[ib];
    if (vb) model[ib] = after_op(ob, model[ib]);
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    check({tag, " R2 a_rvalid"}, a_rvalid, va);
    check({tag, " R6 b_rvalid"}, b_rvalid, vb);
    if (va) check({tag, " a_rdata"}, a_rdata, ea);
    if (vb) check({tag, " b_rdata"}, b_rdata, eb);
  endtask

  initial begin
    for (int i = 0; i < NUM; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 a_rvalid idle", a_rvalid, 1'b0);
    check("R1 b_rvalid idle", b_rvalid, 1'b0);
    // R1: every register reads 0 after reset
    for (int i = 0; i < NUM / 2; i++)
      step(1, 2'b00, 2 * i, 1, 2'b11, 2 * i + 1, "R1 sweep");
    // R3 then R5: grab returns 0, second peek sees 1
    step(1, 2'b01, 5, 0, 2'b00, 0, "R3 grab");
    step(1, 2'b00, 5, 1, 2'b11, 5, "R5 peek");
    step(1, 2'b01, 5, 0, 2'b00, 0, "R3 regrab");
    // R4 clear
    step(0, 2'b00, 0, 1, 2'b10, 5, "R4 drop");
    step(1, 2'b00, 5, 0, 2'b00, 0, "R4 after drop");
    // R7 both grab same bit
    step(1, 2'b01, 9, 1, 2'b01, 9, "R7 grab pair");
    // R8 set then clear, clear then set
    step(1, 2'b01, 12, 1, 2'b10, 12, "R8 set-drop");
    step(1, 2'b00, 12, 0, 2'b00, 0, "R8 result0");
    step(1, 2'b10, 9, 1, 2'b01, 9, "R8 drop-set");
    step(1, 2'b00, 9, 0, 2'b00, 0, "R8 result1");
    // R6 distinct bits both written in one cycle
    step(1, 2'b01, 100, 1, 2'b01, 200, "R6 pair");
    step(1, 2'b00, 100, 1, 2'b00, 200, "R6 readback");
    // R9 neighbours untouched
    step(1, 2'b00, 99, 1, 2'b00, 101, "R9 neighbours");
    // barrier: both cores raise own flag, then poll the other
    step(1, 2'b01, 40, 1, 2'b01, 41, "R3 barrier arrive");
    step(1, 2'b00, 41, 1, 2'b00, 40, "R5 barrier poll");
    // random phase, small window to force collisions
    void'($urandom(32'h1234));
    for (int n = 0; n < 3000; n++)
      step(1'($urandom), 2'($urandom), int'($urandom % 8),
           1'($urandom), 2'($urandom), int'($urandom % 8), "R7 random");
    // R9 full sweep vs model
    for (int i = 0; i < NUM / 2; i++)
      step(1, 2'b00, i, 1, 2'b00, NUM - 1 - i, "R9 sweep");
    summary();
  end
endmodule